// File: doc/BRIEF.md
# Rotating Slice Signature Port

This block publishes a fixed 16-bit board signature through an 8-bit read port, one 4-bit slice per read. Every byte it returns carries both the slice and a 2-bit tag naming which slice it is, so a reader can place each slice correctly no matter where in the rotation it started. A small index register inside the block moves to the next slice each time a read completes. Four completed reads therefore cover the whole signature.

The port is a stream source. `id_valid` says a byte is on offer, `id_ready` is the reader's request, and a read completes on a rising clock edge where both are high. After reset the source withholds data for a parameterised settling interval, which stands in for the wait a reader must observe after resetting the board. A reader may hold `id_ready` low for as long as it likes; while it does, the offered byte does not change. Raising `id_ready` while `id_valid` is low has no effect.

A built-in assembler watches the completed reads. It places each slice at the bit offset given by its tag and gives a verdict after every fourth read: the signature either equals the expected value or it does not.

Top module: `board_sig_port`

## Requirements
- R1: While `rst_n` is low, `id_valid` is 0, `id_data` is 8'h00, and both `sig_match` and `sig_mismatch` are 0. `id_data` stays 8'h00 whenever `id_valid` is 0.
- R2: `id_valid` goes high on exactly the SETTLE_CYCLES-th rising edge after `rst_n` is released. It then stays high until the next reset.
- R3: While `id_valid` is high and the current slice index is k, `id_data[7:4]` equals SIGNATURE[4k+3:4k], `id_data[3:2]` is 2'b00 and `id_data[1:0]` equals k.
- R4: A completed read (`id_valid` and `id_ready` both high at a rising edge) moves k to (k+1) mod 4. The first byte offered after reset has k = 0.
- R5: While `id_ready` is low, k holds and `id_data` is stable. This is the back-pressure rule.
- R6: `id_ready` is ignored while `id_valid` is low, including during the settling interval. The first byte offered afterwards still has k = 0.
- R7: The assembler ORs each read's slice into bit offset 4 × tag. On every fourth completed read since reset it sets `sig_match` if the assembled word equals EXPECTED.
- R8: Otherwise the fourth read sets `sig_mismatch`; a group in which any byte had bits 3:2 non-zero always ends in a mismatch. At most one flag is high. A flag holds until the next completed read, which clears it.
- R9: The assembled word does not depend on the tag of the group's first byte. A group entered at any of tags 0–3 yields the same verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_ready | input | 1 | Reader requests a byte; a read completes when this and `id_valid` are both high at a rising edge |
| id_valid | output | 1 | A signature byte is on offer |
| id_data | output | 8 | Slice in [7:4], zero in [3:2], slice tag in [1:0] |
| sig_match | output | 1 | Last group of four reads assembled to EXPECTED |
| sig_mismatch | output | 1 | Last group of four reads did not assemble to EXPECTED |

## Verification
Two things can happen on the same edge. The read that closes a group sets a verdict while the index register steps to the next slice. On the following edge, a new read can clear that verdict while it also begins the next group. The vector table drives back-to-back reads across group boundaries, and it also drives reads with gaps. After each edge it compares the tag, the slice and both flags with values worked out from the signature. A second instance built with a wrong expected value must show the opposite verdict. The assembler is also driven on its own with groups that begin at tags 2 and 3, with corrupted slices and with reserved bits set. This shows that placement is based on the tag and not on arrival order.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int SIG_W   = 16;
  localparam int SLICE_W = 4;
  localparam int SLICES  = SIG_W / SLICE_W;
  localparam int TAG_W   = $clog2(SLICES);

  typedef logic [TAG_W-1:0] tag_t;

  // Build the published byte for slice k of a signature.
  function automatic logic [7:0] pack_byte(input logic [SIG_W-1:0] sig, input tag_t k);
    return {sig[k*SLICE_W +: SLICE_W], 2'b00, k};
  endfunction

  // Move the slice of a published byte to the bit offset named by its tag.
  function automatic logic [SIG_W-1:0] place_slice(input logic [7:0] b);
    logic [SIG_W-1:0] w;
    w = SIG_W'(b[7:4]);
    return w << {b[1:0], 2'b00};
  endfunction
endpackage

// File: rtl/sig_settle_timer.sv
module sig_settle_timer #(
  parameter int SETTLE_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic settled_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign settled_o = (cnt == LIMIT);

  // R2
  settled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled_o |=> settled_o);
endmodule

// File: rtl/sig_slice_rotator.sv
module sig_slice_rotator
  import sig_pkg::*;
#(
  parameter logic [SIG_W-1:0] SIGNATURE = 16'h3C5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       live_i,
  input  logic       take_i,
  output logic [7:0] byte_o
);
  tag_t idx;
  logic fire;

  assign fire = live_i && take_i;

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (fire) idx <= idx + 1'b1;
  end

  assign byte_o = live_i ? pack_byte(SIGNATURE, idx) : 8'h00;

  // R4
  tag_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> byte_o[1:0] == $past(byte_o[1:0]) + 2'd1);

  // R5
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !take_i) |=> $stable(byte_o));
endmodule

// File: rtl/sig_assembler.sv
module sig_assembler
  import sig_pkg::*;
#(
  parameter logic [SIG_W-1:0] EXPECTED = 16'h3C5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic [7:0] byte_i,
  output logic       match_o,
  output logic       mismatch_o
);
  logic [TAG_W-1:0] seen;
  logic [SIG_W-1:0] acc;
  logic             poisoned;
  logic [SIG_W-1:0] acc_next;
  logic             poisoned_next;
  logic             last;

  assign acc_next      = acc | place_slice(byte_i);
  assign poisoned_next = poisoned | (byte_i[3:2] != 2'b00);
  assign last          = (seen == TAG_W'(SLICES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen       <= '0;
      acc        <= '0;
      poisoned   <= 1'b0;
      match_o    <= 1'b0;
      mismatch_o <= 1'b0;
    end else if (fire_i) begin
      if (last) begin
        match_o    <= !poisoned_next && (acc_next == EXPECTED);
        mismatch_o <= poisoned_next || (acc_next != EXPECTED);
        seen       <= '0;
        acc        <= '0;
        poisoned   <= 1'b0;
      end else begin
        match_o    <= 1'b0;
        mismatch_o <= 1'b0;
        seen       <= seen + 1'b1;
        acc        <= acc_next;
        poisoned   <= poisoned_next;
      end
    end
  end

  // R8
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_o && mismatch_o));

  // R7
  match_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) |-> $past(fire_i));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> ($stable(match_o) && $stable(mismatch_o)));
endmodule

// File: rtl/board_sig_port.sv
module board_sig_port
  import sig_pkg::*;
#(
  parameter logic [15:0] SIGNATURE     = 16'h3C5A,
  parameter logic [15:0] EXPECTED      = SIGNATURE,
  parameter int          SETTLE_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_ready,
  output logic       id_valid,
  output logic [7:0] id_data,
  output logic       sig_match,
  output logic       sig_mismatch
);
  logic settled;
  logic read_done;

  sig_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .settled_o (settled)
  );

  sig_slice_rotator #(.SIGNATURE(SIGNATURE)) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .live_i (settled),
    .take_i (id_ready),
    .byte_o (id_data)
  );

  assign id_valid  = settled;
  assign read_done = settled && id_ready;

  sig_assembler #(.EXPECTED(EXPECTED)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (read_done),
    .byte_i     (id_data),
    .match_o    (sig_match),
    .mismatch_o (sig_mismatch)
  );

  // R1
  idle_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> id_data == 8'h00);
endmodule

// File: tb/board_sig_port_test.sv
module board_sig_port_test;
  localparam logic [15:0] SIG    = 16'h3C5A;
  localparam logic [15:0] BADEXP = 16'h3C5B;
  localparam int          SETTLE = 12;

  // {ready, expected tag k[1:0], match after edge, mismatch after edge}
  localparam logic [4:0] VEC [0:11] = '{
    5'b1_00_0_0, 5'b0_01_0_0, 5'b1_01_0_0, 5'b1_10_0_0,
    5'b0_11_0_0, 5'b1_11_1_0, 5'b0_00_1_0, 5'b1_00_0_0,
    5'b1_01_0_0, 5'b1_10_0_0, 5'b1_11_1_0, 5'b1_00_0_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_ready = 1'b0;
  logic id_valid, bad_valid;
  logic [7:0] id_data, bad_data;
  logic sig_match, sig_mismatch, bad_match, bad_mismatch;
  logic a_fire = 1'b0;
  logic [7:0] a_byte = 8'h00;
  logic a_match, a_mismatch;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  board_sig_port #(.SIGNATURE(SIG), .EXPECTED(SIG), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .id_ready(id_ready), .id_valid(id_valid),
    .id_data(id_data), .sig_match(sig_match), .sig_mismatch(sig_mismatch));

  board_sig_port #(.SIGNATURE(SIG), .EXPECTED(BADEXP), .SETTLE_CYCLES(SETTLE)) uut_bad (
    .clk(clk), .rst_n(rst_n), .id_ready(id_ready), .id_valid(bad_valid),
    .id_data(bad_data), .sig_match(bad_match), .sig_mismatch(bad_mismatch));

  sig_assembler #(.EXPECTED(SIG)) asm_alone (
    .clk(clk), .rst_n(rst_n), .fire_i(a_fire), .byte_i(a_byte),
    .match_o(a_match), .mismatch_o(a_mismatch));

  function automatic logic [7:0] exp_byte(input logic [1:0] k);
    return {SIG[k*4 +: 4], 2'b00, k};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!id_valid && n < 100) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic feed(input logic [7:0] b);
    a_fire = 1'b1; a_byte = b;
    @(posedge clk); @(negedge clk);
    a_fire = 1'b0; a_byte = 8'hFF;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid in reset", 16'(id_valid), 16'h0);
    chk("R1", "data in reset", 16'(id_data), 16'h0);
    chk("R1", "flags in reset", {14'h0, sig_match, sig_mismatch}, 16'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "data while settling", 16'(id_data), 16'h0);
    wait_valid(n);
    chk("R2", "settle edges", 16'(n + 1), 16'(SETTLE));

    // Vector walk
    for (int i = 0; i < 12; i++) begin
      chk("R3", "offered byte", 16'(id_data), 16'(exp_byte(VEC[i][3:2])));
      chk("R2", "valid stays high", 16'(id_valid), 16'h1);
      id_ready = VEC[i][4];
      @(posedge clk); @(negedge clk);
      chk("R7", "match flag", 16'(sig_match), 16'(VEC[i][1]));
      chk("R8", "mismatch flag", 16'(sig_mismatch), 16'(VEC[i][0]));
      chk("R8", "wrong-expect match", 16'(bad_match), 16'h0);
      chk("R8", "wrong-expect mismatch", 16'(bad_mismatch), 16'(VEC[i][1]));
    end
    // back-pressure: ready low for several cycles
    id_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", "byte held under back-pressure", 16'(id_data), 16'(exp_byte(2'd1)));
    id_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R4", "tag after read", 16'(id_data), 16'(exp_byte(2'd2)));

    // Reset mid-stream with ready held high throughout
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1", "valid after mid reset", 16'(id_valid), 16'h0);
    chk("R1", "data after mid reset", 16'(id_data), 16'h0);
    rst_n = 1'b1;
    wait_valid(n);
    chk("R2", "settle edges after mid reset", 16'(n), 16'(SETTLE));
    chk("R6", "first tag after ignored ready", 16'(id_data), 16'(exp_byte(2'd0)));
    @(posedge clk); @(negedge clk);
    chk("R4", "tag after first read", 16'(id_data), 16'(exp_byte(2'd1)));
    id_ready = 1'b0;

    // Standalone assembler: group entered at tag 2, with idle gaps
    feed(exp_byte(2'd2));
    repeat (2) @(negedge clk);
    feed(exp_byte(2'd3));
    feed(exp_byte(2'd0));
    chk("R8", "no verdict mid-group", {14'h0, a_match, a_mismatch}, 16'h0);
    feed(exp_byte(2'd1));
    chk("R9", "group from tag 2 matches", {14'h0, a_match, a_mismatch}, 16'h2);
    repeat (2) @(negedge clk);
    chk("R8", "verdict held while idle", {14'h0, a_match, a_mismatch}, 16'h2);
    feed(exp_byte(2'd2) ^ 8'h10);
    chk("R8", "verdict cleared by next read", {14'h0, a_match, a_mismatch}, 16'h0);
    feed(exp_byte(2'd3));
    feed(exp_byte(2'd0));
    feed(exp_byte(2'd1));
    chk("R8", "corrupt slice mismatches", {14'h0, a_match, a_mismatch}, 16'h1);
    feed(exp_byte(2'd3));
    feed(exp_byte(2'd0) | 8'h04);
    feed(exp_byte(2'd1));
    feed(exp_byte(2'd2));
    chk("R8", "reserved bits poison group", {14'h0, a_match, a_mismatch}, 16'h1);
    feed(exp_byte(2'd3));
    feed(exp_byte(2'd0));
    feed(exp_byte(2'd1));
    feed(exp_byte(2'd2));
    chk("R9", "group from tag 3 matches", {14'h0, a_match, a_mismatch}, 16'h2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule